// File: doc/BRIEF.md
# Write-then-read ordering guard

The guard sits between an execution pipeline and an external bus. In that pipeline the read phase of an instruction comes before the write phase. As a result, a read that follows a write in program order can reach the bus first. The guard takes a read channel and a write channel, each carrying an address and a program-order tag. It merges them into one request stream, at most one request per cycle, and holds back any read that would overtake an older write it depends on.

A dependency exists in two cases. The first is a write and a read of the same address, in any part of the address map. The second is a write and a read that both fall inside a protected address window, which by default covers the peripheral zone from 0x4000 to 0x5FFF inclusive. The guard keeps up to WIN writes that have been issued but not yet completed. It retires the oldest of them on each `bus_done` pulse. Order is kept only by stall cycles: no request is dropped or reordered past an older dependency, and traffic with no dependency passes straight through.

Top module: `wr_order_guard`

## Requirements
- R1: Reset empties the window of outstanding writes. After reset, with idle inputs, `bus_req` is low, and a read inside the protected window is issued in the cycle it is presented.
- R2: A read inside the protected window is stalled (`rd_stall`=1, no read on the bus) while an older, incomplete write inside the window is outstanding. This holds even when the two addresses differ.
- R3: A stalled read stays stalled in the cycle `bus_done` retires its blocking write. It is issued in the following cycle.
- R4: A read is stalled behind an older incomplete or same-cycle write to the identical address, in any part of the address map.
- R5: A read with no dependency is issued in the cycle it is presented, with no added stall. This includes a read just outside the window while a window write is pending.
- R6: When a write presented in the same cycle is older than the read and conflicts with it, the write is issued (`bus_we`=1) and the read is stalled.
- R7: When both channels are valid and no dependency exists, the read takes the bus and the write is stalled.
- R8: A write that is younger than the read does not block it. Tag rule: a write is older than a read when (read_tag - write_tag) mod 2^TAGW lies in 1 to 2^(TAGW-1)-1.
- R9: With WIN writes outstanding, a new write is stalled, including in the cycle of a `bus_done`.
- R10: A write to the same address as an older read that is being held is stalled, so it cannot pass that read.
- R11: In each cycle `bus_req` is high exactly when one channel is accepted (valid and not stalled). `bus_we`, `bus_addr` and `bus_tag` carry that request, with `bus_we`=1 for a write and 0 for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request present |
| rd_addr | input | AW | Read address |
| rd_tag | input | TAGW | Program-order tag of the read |
| wr_valid | input | 1 | Write request present |
| wr_addr | input | AW | Write address |
| wr_tag | input | TAGW | Program-order tag of the write |
| bus_done | input | 1 | Oldest outstanding write has completed on the bus |
| rd_stall | output | 1 | Read not accepted this cycle, hold it |
| wr_stall | output | 1 | Write not accepted this cycle, hold it |
| bus_req | output | 1 | Request issued to the bus this cycle |
| bus_we | output | 1 | Issued request is a write |
| bus_addr | output | AW | Address of the issued request |
| bus_tag | output | TAGW | Tag of the issued request |

## Verification
The guard is driven with the following patterns:
- region reads behind a pending region write at a different address, which sets the region rule apart from the same-address rule;
- same-address pairs outside the region, which show the same-address rule works on its own;
- unrelated reads and writes presented together, which show arbitration ahead of any blocking;
- reads that are older than a pending write, which show the tag direction matters.

Further patterns cover:
- a full window;
- a younger write aimed at a held read;
- tags that wrap through zero;
- addresses at both edges of the window.

Each release is checked in the exact cycle after `bus_done`.

// File: rtl/wr_order_guard.sv
module wr_order_guard #(
  parameter int AW = 22,
  parameter int TAGW = 4,
  parameter int WIN = 3,
  parameter logic [AW-1:0] PROT_LO = 22'h004000,
  parameter logic [AW-1:0] PROT_HI = 22'h005FFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_valid,
  input  logic [AW-1:0]   rd_addr,
  input  logic [TAGW-1:0] rd_tag,
  input  logic            wr_valid,
  input  logic [AW-1:0]   wr_addr,
  input  logic [TAGW-1:0] wr_tag,
  input  logic            bus_done,
  output logic            rd_stall,
  output logic            wr_stall,
  output logic            bus_req,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [TAGW-1:0] bus_tag
);
  localparam int CW = $clog2(WIN + 1);

  function automatic logic older(input logic [TAGW-1:0] w, input logic [TAGW-1:0] r);
    logic [TAGW-1:0] d;
    d = r - w;
    return (d != '0) && !d[TAGW-1];
  endfunction

  function automatic logic in_prot(input logic [AW-1:0] a);
    return (a >= PROT_LO) && (a <= PROT_HI);
  endfunction

  logic [AW-1:0]   ent_a [WIN];
  logic [TAGW-1:0] ent_t [WIN];
  logic [WIN-1:0]  ent_p;
  logic [WIN-1:0]  hit;
  logic [CW-1:0]   cnt;

  logic rd_prot, wr_prot, full, pop, push;
  logic cur_blk, rd_blk, rd_go, wr_go, wr_after_rd;

  assign rd_prot = in_prot(rd_addr);
  assign wr_prot = in_prot(wr_addr);
  assign full    = (cnt == CW'(WIN));
  assign pop     = bus_done && (cnt != '0);

  for (genvar g = 0; g < WIN; g++) begin : g_cmp
    assign hit[g] = (CW'(g) < cnt) && older(ent_t[g], rd_tag) &&
                    ((ent_a[g] == rd_addr) || (ent_p[g] && rd_prot));
  end

  assign cur_blk = wr_valid && older(wr_tag, rd_tag) &&
                   ((wr_addr == rd_addr) || (wr_prot && rd_prot));
  assign rd_blk  = rd_valid && ((|hit) || cur_blk);
  assign rd_go   = rd_valid && !rd_blk;

  assign wr_after_rd = rd_blk && older(rd_tag, wr_tag) && (rd_addr == wr_addr);
  assign wr_go   = wr_valid && !full && !rd_go && !wr_after_rd;
  assign push    = wr_go;

  assign rd_stall = rd_valid && !rd_go;
  assign wr_stall = wr_valid && !wr_go;
  assign bus_req  = rd_go || wr_go;
  assign bus_we   = wr_go;
  assign bus_addr = wr_go ? wr_addr : (rd_go ? rd_addr : '0);
  assign bus_tag  = wr_go ? wr_tag  : (rd_go ? rd_tag  : '0);

  logic [CW-1:0] wpos;
  assign wpos = cnt - CW'(pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      ent_p <= '0;
      for (int i = 0; i < WIN; i++) begin
        ent_a[i] <= '0;
        ent_t[i] <= '0;
      end
    end else begin
      if (pop) begin
        for (int i = 0; i < WIN - 1; i++) begin
          ent_a[i] <= ent_a[i+1];
          ent_t[i] <= ent_t[i+1];
          ent_p[i] <= ent_p[i+1];
        end
        ent_p[WIN-1] <= 1'b0;
      end
      if (push) begin
        for (int i = 0; i < WIN; i++) begin
          if (CW'(i) == wpos) begin
            ent_a[i] <= wr_addr;
            ent_t[i] <= wr_tag;
            ent_p[i] <= wr_prot;
          end
        end
      end
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/wr_order_guard_chk.sv
module wr_order_guard_chk #(
  parameter int AW = 22,
  parameter int TAGW = 4,
  parameter int WIN = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_valid,
  input logic [AW-1:0]   rd_addr,
  input logic [TAGW-1:0] rd_tag,
  input logic            wr_valid,
  input logic [AW-1:0]   wr_addr,
  input logic [TAGW-1:0] wr_tag,
  input logic            bus_done,
  input logic            rd_stall,
  input logic            wr_stall,
  input logic            bus_req,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr
);
  localparam int CW = $clog2(WIN + 1);
  logic [CW-1:0] sc;
  logic rd_acc, wr_acc, wr_first;
  logic [TAGW-1:0] tdiff;

  assign rd_acc = rd_valid && !rd_stall;
  assign wr_acc = wr_valid && !wr_stall;
  assign tdiff  = rd_tag - wr_tag;
  assign wr_first = (tdiff != '0) && !tdiff[TAGW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) sc <= '0;
    else sc <= sc + CW'(wr_acc) - CW'(bus_done && sc != '0);
  end

  AST_FULL_HOLDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sc == CW'(WIN) && wr_valid) |-> wr_stall); // R9
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_acc && wr_acc)); // R11
  AST_REQ_MATCHES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req == (rd_acc || wr_acc)); // R11
  AST_READ_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |-> (!bus_we && bus_addr == rd_addr)); // R7
  AST_EMPTY_READ_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (sc == '0 && rd_valid && !wr_valid) |-> !rd_stall); // R5
  AST_SAME_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && wr_valid && rd_addr == wr_addr && wr_first) |-> rd_stall); // R4
endmodule

bind wr_order_guard wr_order_guard_chk #(.AW(AW), .TAGW(TAGW), .WIN(WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_tag(rd_tag),
  .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_tag(wr_tag), .bus_done(bus_done),
  .rd_stall(rd_stall), .wr_stall(wr_stall), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr)
);

// File: tb/wr_order_guard_test.sv
module wr_order_guard_test;
  localparam int AW = 22;
  localparam int TAGW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_valid = 1'b0, wr_valid = 1'b0, bus_done = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [TAGW-1:0] rd_tag = '0, wr_tag = '0;
  logic rd_stall, wr_stall, bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [TAGW-1:0] bus_tag;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  wr_order_guard uut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_tag(rd_tag),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_tag(wr_tag), .bus_done(bus_done),
    .rd_stall(rd_stall), .wr_stall(wr_stall), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_tag(bus_tag)
  );

  typedef struct packed {
    logic rv; logic [AW-1:0] ra; logic [TAGW-1:0] rt;
    logic wv; logic [AW-1:0] wa; logic [TAGW-1:0] wt;
    logic bd;
    logic xrs; logic xws; logic xbr; logic xbw; logic [AW-1:0] xba;
    logic [7:0] rq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{0, 22'h0,      0, 0, 22'h0,      0, 0, 0,0,0,0, 22'h0,      11}, // R11 idle
    '{0, 22'h0,      0, 1, 22'h4010,   1, 0, 0,0,1,1, 22'h4010,   11}, // R11 write issue
    '{1, 22'h4020,   2, 0, 22'h0,      0, 0, 1,0,0,0, 22'h0,       2}, // R2
    '{1, 22'h4020,   2, 0, 22'h0,      0, 1, 1,0,0,0, 22'h0,       3}, // R3 done cycle
    '{1, 22'h4020,   2, 0, 22'h0,      0, 0, 0,0,1,0, 22'h4020,    3}, // R3 release
    '{0, 22'h0,      0, 1, 22'h0100,   3, 0, 0,0,1,1, 22'h0100,   11},
    '{1, 22'h0200,   4, 0, 22'h0,      0, 0, 0,0,1,0, 22'h0200,    5}, // R5
    '{1, 22'h0100,   5, 0, 22'h0,      0, 0, 1,0,0,0, 22'h0,       4}, // R4
    '{0, 22'h0,      0, 0, 22'h0,      0, 1, 0,0,0,0, 22'h0,      11},
    '{1, 22'h0100,   5, 0, 22'h0,      0, 0, 0,0,1,0, 22'h0100,    4}, // R4 after done
    '{1, 22'h4002,   7, 1, 22'h5000,   6, 0, 1,0,1,1, 22'h5000,    6}, // R6
    '{1, 22'h4002,   7, 0, 22'h0,      0, 1, 1,0,0,0, 22'h0,       3}, // R3
    '{1, 22'h4002,   7, 0, 22'h0,      0, 0, 0,0,1,0, 22'h4002,    3}, // R3
    '{1, 22'h0300,   9, 1, 22'h0400,   8, 0, 0,1,1,0, 22'h0300,    7}, // R7
    '{0, 22'h0,      0, 1, 22'h4400,   8, 0, 0,0,1,1, 22'h4400,   11},
    '{1, 22'h4500,   7, 0, 22'h0,      0, 0, 0,0,1,0, 22'h4500,    8}, // R8
    '{0, 22'h0,      0, 1, 22'h0500,  10, 0, 0,0,1,1, 22'h0500,   11},
    '{0, 22'h0,      0, 1, 22'h0600,  11, 0, 0,0,1,1, 22'h0600,   11},
    '{0, 22'h0,      0, 1, 22'h0700,  12, 0, 0,1,0,0, 22'h0,       9}, // R9
    '{0, 22'h0,      0, 1, 22'h0700,  12, 1, 0,1,0,0, 22'h0,       9}, // R9 done cycle
    '{0, 22'h0,      0, 1, 22'h0700,  12, 0, 0,0,1,1, 22'h0700,    9}, // R9
    '{0, 22'h0,      0, 0, 22'h0,      0, 1, 0,0,0,0, 22'h0,      11},
    '{1, 22'h0600,  13, 1, 22'h0600,  14, 0, 1,1,0,0, 22'h0,      10}, // R10
    '{1, 22'h0600,  13, 1, 22'h0600,  14, 1, 1,1,0,0, 22'h0,      10}, // R10
    '{1, 22'h0600,  13, 1, 22'h0600,  14, 0, 0,1,1,0, 22'h0600,    7}, // R7
    '{0, 22'h0,      0, 1, 22'h0600,  14, 0, 0,0,1,1, 22'h0600,   11},
    '{1, 22'h4000,   1, 1, 22'h5FFF,  15, 0, 1,0,1,1, 22'h5FFF,    6}, // R6 wrap
    '{1, 22'h6000,   1, 0, 22'h0,      0, 0, 0,0,1,0, 22'h6000,    5}  // R5 edge
  };

  task automatic chk(input string nm, input logic [AW-1:0] act, input logic [AW-1:0] exp, input int rq);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, nm, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    rd_valid = v.rv; rd_addr = v.ra; rd_tag = v.rt;
    wr_valid = v.wv; wr_addr = v.wa; wr_tag = v.wt; bus_done = v.bd;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("bus_req in reset (R1)", AW'(bus_req), '0, 1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #2;
      chk("rd_stall", AW'(rd_stall), AW'(VEC[i].xrs), VEC[i].rq);
      chk("wr_stall", AW'(wr_stall), AW'(VEC[i].xws), VEC[i].rq);
      chk("bus_req", AW'(bus_req), AW'(VEC[i].xbr), VEC[i].rq);
      if (VEC[i].xbr) begin
        chk("bus_we", AW'(bus_we), AW'(VEC[i].xbw), VEC[i].rq);
        chk("bus_addr", bus_addr, VEC[i].xba, VEC[i].rq);
      end
    end
    // R1: reset with pending region write, then region read goes through
    @(negedge clk);
    drive('{0, 22'h0, 0, 1, 22'h4100, 2, 0, 0,0,0,0, 22'h0, 1});
    @(negedge clk);
    drive('0);
    rst_n = 1'b0;
    @(negedge clk);
    #2;
    chk("bus_req idle in reset R1", AW'(bus_req), '0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    drive('{1, 22'h4200, 3, 0, 22'h0, 0, 0, 0,0,0,0, 22'h0, 1});
    #2;
    chk("rd_stall after reset R1", AW'(rd_stall), '0, 1);
    chk("bus_addr after reset R1", bus_addr, 22'h4200, 1);
    // R11: tag carried with the read
    chk("bus_tag R11", AW'(bus_tag), AW'(4'd3), 11);
    @(negedge clk);
    drive('0);
    @(negedge clk);
    finish_run();
  end
endmodule